// File: doc/BRIEF.md
# Selectable Synchronizer and Noise-Filter Delay Stage

A single-bit delay element that runs on its own stage clock. That clock may be slower than, and independent of, any clock used by surrounding logic. A two-entry truth table first maps the data input, so the stage can buffer or invert it. The mapped bit then takes one of three paths, chosen by a two-bit mode input.

- Bypass is a purely combinational path.
- Synchronize is a short flop pipeline that also widens any captured pulse to at least two stage clocks.
- Filter lets a new level through only after it has been sampled on four consecutive stage clocks.

The stage is meant to be instantiated as the timing element inside larger pulse-shaping blocks, such as stretchers and edge detectors. In those blocks a delayed copy of a signal is fed back to set or clear other logic. A synchronous reset clears every internal flop. A change of mode is registered on the next stage clock and flushes the pipeline at the same time.

Top module: `dly_stage`

## Requirements
- R1: While `rst` is high, `dout` is low. A clock edge with `rst` high clears all history, so the first stage-clock sample taken after reset is the oldest one the stage holds.
- R2: When the registered mode is bypass (`mode` 2'b00, and also the unused code 2'b11), `dout` equals the mapped input with no clocked delay.
- R3: The mapped input is `tt[din]`: `tt` = 2'b10 passes `din` unchanged and `tt` = 2'b01 inverts it.
- R4: In synchronize mode (`mode` 2'b01), a mapped value first sampled at a stage-clock edge appears on `dout` after the following edge, which is the second edge counting the sampling edge.
- R5: In synchronize mode, a high level captured at even a single edge keeps `dout` high for at least two stage clocks. `dout` falls after the third edge following the last high sample.
- R6: In filter mode (`mode` 2'b10), `dout` takes a new level at the fourth consecutive edge that samples that level.
- R7: In filter mode, a run of fewer than four samples at the opposite level leaves `dout` unchanged, and the count of consecutive samples starts again.
- R8: A new `mode` value takes effect at the next stage-clock edge and not before. That edge clears the pipeline, so a newly entered synchronize or filter mode outputs low until fresh samples pass through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stage clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 bypass, 01 synchronize, 10 filter, 11 bypass |
| tt | input | 2 | Truth table: bit n is the output when `din` is n |
| din | input | 1 | Data input |
| dout | output | 1 | Delayed or filtered data output |

## Verification
The properties assume that `din`, `tt` and `mode` are stable around each rising stage-clock edge. Each property also requires that several cycles have passed since reset and that the mode has held steady over the window it examines, because a reset or a flush legitimately shortens a pulse. The bench changes every input at the falling edge, or within a few time units of a rising edge but never on it. It always waits out the flush edge after a mode change before checking delay counts, and it places its sub-clock pulse so that it covers exactly one rising edge.

// File: rtl/dly_stage.sv
`timescale 1ns/1ps
module dly_stage #(
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic [1:0] tt,
  input  logic       din,
  output logic       dout
);
  localparam int SHW = (FILT_LEN > 4) ? FILT_LEN - 1 : 3;
  localparam int FW  = FILT_LEN - 1;
  localparam logic [1:0] M_SYN = 2'b01;
  localparam logic [1:0] M_FLT = 2'b10;

  logic [1:0]     mode_q;
  logic [SHW-1:0] sh;
  logic           flt_q;

  wire mapped  = tt[din];
  wire mchg    = (mode != mode_q);
  wire settled = (sh[FW-1:0] == {FW{mapped}});

  always_ff @(posedge clk) begin
    if (rst || mchg) begin
      mode_q <= mode;
      sh     <= '0;
      flt_q  <= 1'b0;
    end else begin
      sh <= {sh[SHW-2:0], mapped};
      if (settled) flt_q <= mapped;
    end
  end

  always_comb begin
    if (rst) dout = 1'b0;
    else begin
      case (mode_q)
        M_SYN:   dout = sh[1] | sh[2];
        M_FLT:   dout = flt_q;
        default: dout = mapped;
      endcase
    end
  end
endmodule

// File: rtl/dly_stage_chk.sv
`timescale 1ns/1ps
module dly_stage_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic [1:0] tt,
  input logic       din,
  input logic       dout
);
  logic [2:0] cnt = '0;
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt != 3'd7) cnt <= cnt + 3'd1;
  end

  // R1
  always @(negedge clk) begin
    if (rst) rst_low_chk: assert (dout == 1'b0);
  end

  // R2
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt >= 3'd1 && ($past(mode) == 2'b00 || $past(mode) == 2'b11)) |-> (dout == tt[din]));

  // R4
  sync_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt >= 3'd4 && $past(mode) == 2'b01 && $past(mode, 2) == 2'b01 && $past(mode, 3) == 2'b01
     && $rose(dout)) |-> $past(tt[din], 2));

  // R5
  sync_stretch_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt >= 3'd4 && $past(mode) == 2'b01 && $past(mode, 2) == 2'b01 && $past(mode, 3) == 2'b01
     && $fell(dout)) |-> $past(dout, 2));

  // R6
  filt_change_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt >= 3'd3 && $past(mode) == 2'b10 && $past(mode, 2) == 2'b10 && !$stable(dout))
    |-> (dout == $past(tt[din])));

  // R8
  flush_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt >= 3'd3 && $past(mode) != $past(mode, 2) && ($past(mode) == 2'b01 || $past(mode) == 2'b10))
    |-> !dout);
endmodule

bind dly_stage dly_stage_chk chk_i (
  .clk(clk), .rst(rst), .mode(mode), .tt(tt), .din(din), .dout(dout)
);

// File: tb/dly_stage_tb_top.sv
`timescale 1ns/1ps
module dly_stage_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic [1:0] tt = 2'b10;
  logic       din = 1'b0;
  logic       dout;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dly_stage dut_i (.clk(clk), .rst(rst), .mode(mode), .tt(tt), .din(din), .dout(dout));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s dout=%b expected=%b at %0t", req, dout, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; mode = 2'b00; tt = 2'b10; din = 1'b1;
    tick(); tick();
    #1 chk("R1", 1'b0);
    rst = 1'b0;
    #1 chk("R2", 1'b1);
  endtask

  task automatic t_bypass();
    din = 1'b0; #1 chk("R2", 1'b0);
    din = 1'b1; #1 chk("R2", 1'b1);
    tt = 2'b01; #1 chk("R3", 1'b0);
    din = 1'b0; #1 chk("R3", 1'b1);
    mode = 2'b11; tick();
    tt = 2'b10; din = 1'b1; #1 chk("R2", 1'b1);
    din = 1'b0; #1 chk("R2", 1'b0);
    mode = 2'b00; tick();
  endtask

  task automatic t_sync();
    din = 1'b0; tt = 2'b10; mode = 2'b01;
    tick(); tick(); tick();
    chk("R4", 1'b0);
    din = 1'b1;
    tick(); chk("R4", 1'b0);
    tick(); chk("R4", 1'b1);
    tick(); chk("R4", 1'b1);
    din = 1'b0;
    tick(); chk("R5", 1'b1);
    tick(); chk("R5", 1'b1);
    tick(); chk("R5", 1'b0);
  endtask

  task automatic t_stretch();
    tick();
    #(CLK_P/2 - 2) din = 1'b1;
    @(posedge clk);
    #2 din = 1'b0;
    @(negedge clk);
    chk("R5", 1'b0);
    tick(); chk("R5", 1'b1);
    tick(); chk("R5", 1'b1);
    tick(); chk("R5", 1'b0);
  endtask

  task automatic t_filter();
    din = 1'b0; tt = 2'b10; mode = 2'b10;
    tick();
    din = 1'b1;
    for (int i = 0; i < 3; i++) begin tick(); chk("R6", 1'b0); end
    tick(); chk("R6", 1'b1);
    din = 1'b0;
    for (int i = 0; i < 3; i++) begin tick(); chk("R7", 1'b1); end
    din = 1'b1;
    tick(); chk("R7", 1'b1);
    din = 1'b0;
    for (int i = 0; i < 3; i++) begin tick(); chk("R7", 1'b1); end
    tick(); chk("R7", 1'b0);
    tt = 2'b01;
    for (int i = 0; i < 3; i++) begin tick(); chk("R3", 1'b0); end
    tick(); chk("R3", 1'b1);
  endtask

  task automatic t_modechg();
    mode = 2'b01;
    #1 chk("R8", 1'b1);
    tick(); chk("R8", 1'b0);
    tick(); chk("R8", 1'b0);
    tick(); chk("R8", 1'b1);
    mode = 2'b00; tt = 2'b10; din = 1'b0;
    #1 chk("R8", 1'b1);
    tick(); chk("R8", 1'b0);
  endtask

  task automatic t_reset_mid();
    mode = 2'b01; tt = 2'b10; din = 1'b1;
    tick(); tick(); tick();
    chk("R4", 1'b1);
    rst = 1'b1;
    #1 chk("R1", 1'b0);
    tick(); chk("R1", 1'b0);
    rst = 1'b0;
    #1 chk("R1", 1'b0);
    tick(); chk("R1", 1'b0);
    tick(); chk("R1", 1'b1);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_sync();
    t_stretch();
    t_filter();
    t_modechg();
    t_reset_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule